// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a virtual address into a physical address by stepping through a tree of translation tables that sits in ordinary memory. A requester hands over a virtual address and the kind of access it wants to make (read, write or execute). The walker then fetches one 64-bit descriptor per level, starting from the table whose address is held in a root base input. The walker fetches through a single-read memory port whose answers may take any number of cycles.

Each level of the tree is picked by a 9-bit field of the address, and every table is one 4 KB page of 512 eight-byte entries. The walk ends in one of three ways: with a physical address and its read/write/execute rights, with a translation fault naming the level where an unusable descriptor was met, or with a permission fault when the final page does not allow the requested access. Only one translation is in flight at a time; the requester waits on a ready signal before offering the next one.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle; a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_valid` raised while `req_ready` is low is ignored and produces no response.
- R2: Each descriptor is read from byte address (table page address) + 8 × index, where the first table page comes from `root_base[47:12]` and the index is `vaddr[47:39]`, `[38:30]`, `[29:21]` and `[20:12]` for levels 0, 1, 2 and 3; `mem_req_addr` stays stable while `mem_req_valid` waits for `mem_req_ready`.
- R3: At most one memory read is outstanding: after a read is accepted, `mem_req_valid` stays low until its `mem_rsp_valid` has arrived.
- R4: A descriptor with bits [1:0] = 11 is a next-table pointer at levels 0 to 2 (next table page in bits [47:12]) and a page descriptor at level 3; any other value of bits [1:0] ends the walk at once with `rsp_fault` = 1 and `rsp_level` equal to the level of that descriptor.
- R5: A successful walk reports `rsp_fault` = 0, `rsp_level` = 3, `rsp_paddr` = {page descriptor bits [47:12], vaddr[11:0]}, and the rights read = descriptor bit 2, write = bit 3, execute = bit 4.
- R6: Access codes are 0 read, 1 write, 2 execute, 3 read; if the page does not grant the requested right, the walk ends with `rsp_fault` = 2, `rsp_level` = 3, `rsp_paddr` = 0 and the page's rights still reported.
- R7: Virtual address bits 63 to 48 have no effect on the walk or its result.
- R8: Every accepted request yields exactly one single-cycle `rsp_valid` pulse; on a translation fault `rsp_paddr` and the three rights read as 0.
- R9: After reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 64 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| root_base | input | 48 | Address of the level-0 table (bits 11..0 ignored) |
| mem_req_valid | output | 1 | Descriptor read requested |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data present |
| mem_rsp_data | input | 64 | Descriptor returned by memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 48 | Physical address (0 on a fault) |
| rsp_perm_r | output | 1 | Page allows reads |
| rsp_perm_w | output | 1 | Page allows writes |
| rsp_perm_x | output | 1 | Page allows execution |
| rsp_fault | output | 2 | 0 none, 1 translation fault, 2 permission fault |
| rsp_level | output | 2 | Level at which the walk ended |

## Verification
On every cycle the assertions watch the handshake rules: no second request taken while a walk runs, a read request held steady until taken, no new read before the previous answer, single-cycle result pulses, a granted right behind every successful result, and permission faults only at the last level. Whether the right table entry was fetched at each level, whether the physical address and offset are assembled correctly, and whether a fault stops at the right level can only be shown by the bench's scenarios, which build real table trees, corrupt single entries and compare each result and each fetched address against a separate model of the walk under varying memory latency.

// File: rtl/ptw_pkg.sv
// Package: shared types for the translation walker.
// Holds the walk states, fault and access encodings and the descriptor
// bit positions of the rights, so every module decodes them alike.
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_XLATE = 2'd1,
        FLT_PERM  = 2'd2
    } fault_t;

    typedef enum logic [1:0] {
        ACC_READ     = 2'd0,
        ACC_WRITE    = 2'd1,
        ACC_EXEC     = 2'd2,
        ACC_READ_ALT = 2'd3
    } access_t;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    localparam int PERM_R_BIT = 2;
    localparam int PERM_W_BIT = 3;
    localparam int PERM_X_BIT = 4;
    localparam logic [1:0] DESC_VALID_CODE = 2'b11;

endpackage

// File: rtl/ptw_index_sel.sv
// Module: selects the table index for the current walk level.
// Assumes level l uses the IDX_BITS field just below the field of level
// l-1, with level 0 starting at the top significant address bit.
module ptw_index_sel #(
    parameter int VA_BITS  = 48,
    parameter int IDX_BITS = 9,
    parameter int LEVELS   = 4,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VA_BITS-1:0]  va,
    input  logic [LVL_W-1:0]    lvl,
    output logic [IDX_BITS-1:0] idx
);

    logic [IDX_BITS-1:0] slice [LEVELS];

    // One fixed slice of the address per level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = va[VA_BITS-1-g*IDX_BITS -: IDX_BITS];
    end

    // Pick the slice of the level being walked.
    always_comb begin
        idx = slice[lvl];
    end

endmodule

// File: rtl/ptw_desc_decode.sv
// Module: classifies one descriptor returned by memory.
// Assumes type code 11 in bits [1:0] means a table pointer below the
// last level and a page at the last level; all other codes are invalid.
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int DESC_BITS = 64,
    parameter int PA_BITS   = 48,
    parameter int PAGE_BITS = 12
) (
    input  logic [DESC_BITS-1:0]         desc,
    input  logic                         last_lvl,
    output logic                         is_table,
    output logic                         is_page,
    output logic                         is_invalid,
    output logic [PA_BITS-PAGE_BITS-1:0] frame,
    output perm_t                        perms
);

    logic unused_desc_bits;

    // Type decode from the two low bits and the level position.
    always_comb begin
        is_invalid = (desc[1:0] != DESC_VALID_CODE);
        is_table   = !is_invalid && !last_lvl;
        is_page    = !is_invalid && last_lvl;
    end

    // Address and rights fields.
    always_comb begin
        frame   = desc[PA_BITS-1:PAGE_BITS];
        perms.r = desc[PERM_R_BIT];
        perms.w = desc[PERM_W_BIT];
        perms.x = desc[PERM_X_BIT];
    end

    assign unused_desc_bits = ^{desc[DESC_BITS-1:PA_BITS], desc[PAGE_BITS-1:PERM_X_BIT+1]};

    // R4: exactly one descriptor class for any known descriptor
    always_comb begin
        if (!$isunknown({desc, last_lvl})) begin
            desc_class_chk: assert ($onehot({is_table, is_page, is_invalid}));
        end
    end

endmodule

// File: rtl/ptw_perm_check.sv
// Module: decides whether a page's rights allow the requested access.
// Assumes access code 3 is treated as a read.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [1:0] access,
    input  perm_t      perms,
    output logic       allowed
);

    // Map the access kind onto the matching right.
    always_comb begin
        unique case (access)
            ACC_WRITE: allowed = perms.w;
            ACC_EXEC:  allowed = perms.x;
            default:   allowed = perms.r;
        endcase
    end

endmodule

// File: rtl/ptw_walker.sv
// Module: four-level translation table walker (top).
// Takes one request at a time, fetches one descriptor per level through a
// single-outstanding read port of any latency, and returns a physical
// address with rights, a translation fault or a permission fault.
// Assumes tables are page aligned and the memory answers every read once.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VADDR_W   = 64,
    parameter int VA_BITS   = 48,
    parameter int PA_BITS   = 48,
    parameter int PAGE_BITS = 12,
    parameter int IDX_BITS  = 9,
    parameter int LEVELS    = 4,
    parameter int DESC_BITS = 64,
    localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int FRAME_W  = PA_BITS - PAGE_BITS,
    localparam int ENTRY_SH = $clog2(DESC_BITS / 8)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VADDR_W-1:0]   req_vaddr,
    input  logic [1:0]           req_access,
    input  logic [PA_BITS-1:0]   root_base,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PA_BITS-1:0]   mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [DESC_BITS-1:0] mem_rsp_data,
    output logic                 rsp_valid,
    output logic [PA_BITS-1:0]   rsp_paddr,
    output logic                 rsp_perm_r,
    output logic                 rsp_perm_w,
    output logic                 rsp_perm_x,
    output logic [1:0]           rsp_fault,
    output logic [LVL_W-1:0]     rsp_level
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_t         state;
    logic [LVL_W-1:0]    lvl_q;
    logic [FRAME_W-1:0]  base_q;
    logic [VA_BITS-1:0]  va_q;
    logic [1:0]          acc_q;
    logic [IDX_BITS-1:0] cur_idx;
    logic                dec_table;
    logic                dec_page;
    logic                dec_invalid;
    logic [FRAME_W-1:0]  dec_frame;
    perm_t               dec_perms;
    logic                perm_ok;
    logic                take_req;
    logic                desc_in;
    logic                unused_in_bits;

    assign unused_in_bits = ^{req_vaddr[VADDR_W-1:VA_BITS], root_base[PAGE_BITS-1:0], dec_page};

    ptw_index_sel #(
        .VA_BITS (VA_BITS),
        .IDX_BITS(IDX_BITS),
        .LEVELS  (LEVELS)
    ) u_index (
        .va (va_q),
        .lvl(lvl_q),
        .idx(cur_idx)
    );

    ptw_desc_decode #(
        .DESC_BITS(DESC_BITS),
        .PA_BITS  (PA_BITS),
        .PAGE_BITS(PAGE_BITS)
    ) u_decode (
        .desc      (mem_rsp_data),
        .last_lvl  (lvl_q == LAST_LVL),
        .is_table  (dec_table),
        .is_page   (dec_page),
        .is_invalid(dec_invalid),
        .frame     (dec_frame),
        .perms     (dec_perms)
    );

    ptw_perm_check u_perm (
        .access (acc_q),
        .perms  (dec_perms),
        .allowed(perm_ok)
    );

    // Handshake qualifiers for the request and the descriptor return.
    always_comb begin
        req_ready = (state == ST_IDLE);
        take_req  = req_valid && req_ready;
        desc_in   = (state == ST_WAIT) && mem_rsp_valid;
    end

    // Descriptor address: table page plus entry size times index.
    always_comb begin
        mem_req_valid = (state == ST_ISSUE);
        mem_req_addr  = {base_q, {PAGE_BITS{1'b0}}}
                      + PA_BITS'({cur_idx, {ENTRY_SH{1'b0}}});
    end

    // Walk sequencer: level, table page and state per descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lvl_q  <= '0;
            base_q <= '0;
            va_q   <= '0;
            acc_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take_req) begin
                        state  <= ST_ISSUE;
                        lvl_q  <= '0;
                        base_q <= root_base[PA_BITS-1:PAGE_BITS];
                        va_q   <= req_vaddr[VA_BITS-1:0];
                        acc_q  <= req_access;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (desc_in) begin
                        if (dec_table) begin
                            state  <= ST_ISSUE;
                            lvl_q  <= lvl_q + 1'b1;
                            base_q <= dec_frame;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result register: one pulse with address, rights and fault code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_perm_r <= 1'b0;
            rsp_perm_w <= 1'b0;
            rsp_perm_x <= 1'b0;
            rsp_fault  <= FLT_NONE;
            rsp_level  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (desc_in && !dec_table) begin
                rsp_valid <= 1'b1;
                rsp_level <= lvl_q;
                if (dec_invalid) begin
                    rsp_fault  <= FLT_XLATE;
                    rsp_paddr  <= '0;
                    rsp_perm_r <= 1'b0;
                    rsp_perm_w <= 1'b0;
                    rsp_perm_x <= 1'b0;
                end else begin
                    rsp_perm_r <= dec_perms.r;
                    rsp_perm_w <= dec_perms.w;
                    rsp_perm_x <= dec_perms.x;
                    if (perm_ok) begin
                        rsp_fault <= FLT_NONE;
                        rsp_paddr <= {dec_frame, va_q[PAGE_BITS-1:0]};
                    end else begin
                        rsp_fault <= FLT_PERM;
                        rsp_paddr <= '0;
                    end
                end
            end
        end
    end

    // R1
    busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ENTRY_SH-1:0] == '0));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    perm_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |->
            ((acc_q == ACC_WRITE) ? rsp_perm_w : (acc_q == ACC_EXEC) ? rsp_perm_x : rsp_perm_r));

    // R6
    perm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_PERM) |-> (rsp_level == LAST_LVL));

endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;

    typedef struct packed {
        logic [47:0] paddr;
        logic [1:0]  fault;
        logic [1:0]  level;
        logic        r;
        logic        w;
        logic        x;
    } result_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [47:0] root_base = 48'h1000;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [47:0] rsp_paddr;
    logic        rsp_perm_r;
    logic        rsp_perm_w;
    logic        rsp_perm_x;
    logic [1:0]  rsp_fault;
    logic [1:0]  rsp_level;

    int checks = 0;
    int fails = 0;
    logic [63:0] tbl [logic [47:0]];
    logic [47:0] next_free = 48'h2000;
    result_t     exp_q [$];
    string       tag_q [$];
    logic [47:0] addr_q [$];

    always #4 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access),
        .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_perm_r(rsp_perm_r), .rsp_perm_w(rsp_perm_w), .rsp_perm_x(rsp_perm_x),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level)
    );

    function automatic logic [63:0] rd(input logic [47:0] a);
        return tbl.exists(a) ? tbl[a] : 64'd0;
    endfunction

    function automatic logic [47:0] ent_addr(input logic [47:0] page, input logic [63:0] va, input int l);
        logic [8:0] ix;
        ix = va[47-9*l -: 9];
        return {page[47:12], 12'h000} + {36'd0, ix, 3'b000};
    endfunction

    function automatic logic [47:0] page_of(input logic [63:0] d);
        return {d[47:12], 12'h000};
    endfunction

    // Address of the level-l entry for va in the bench's own tables.
    function automatic logic [47:0] entry_of(input logic [63:0] va, input int l);
        logic [47:0] page;
        page = root_base;
        for (int k = 0; k < l; k++) page = page_of(rd(ent_addr(page, va, k)));
        return ent_addr(page, va, l);
    endfunction

    // Build tables so va maps to page pa with rights {x,w,r}.
    task automatic map_page(input logic [63:0] va, input logic [47:0] pa, input logic [2:0] xwr);
        logic [47:0] page;
        logic [47:0] a;
        logic [63:0] e;
        page = root_base;
        for (int l = 0; l < 3; l++) begin
            a = ent_addr(page, va, l);
            e = rd(a);
            if (e[1:0] != 2'b11) begin
                e = {16'd0, next_free} | 64'd3;
                next_free = next_free + 48'h1000;
                tbl[a] = e;
            end
            page = page_of(e);
        end
        a = ent_addr(page, va, 3);
        tbl[a] = {16'd0, pa[47:12], 7'd0, xwr, 2'b11};
    endtask

    // Reference walk from the requirements; also queues expected reads.
    task automatic model(input logic [63:0] va, input logic [1:0] acc, output result_t res);
        logic [47:0] page;
        logic [47:0] a;
        logic [63:0] e;
        logic        ok;
        page = root_base;
        res = '0;
        for (int l = 0; l < 4; l++) begin
            a = ent_addr(page, va, l);
            addr_q.push_back(a);
            e = rd(a);
            if (e[1:0] != 2'b11) begin
                res.fault = 2'd1;
                res.level = 2'(l);
                return;
            end
            page = page_of(e);
        end
        res.level = 2'd3;
        res.r = e[2];
        res.w = e[3];
        res.x = e[4];
        ok = (acc == 2'd1) ? res.w : (acc == 2'd2) ? res.x : res.r;
        if (ok) res.paddr = {e[47:12], va[11:0]};
        else res.fault = 2'd2;
    endtask

    // Driver: compute expectation, push it, then hand over the request.
    task automatic send(input logic [63:0] va, input logic [1:0] acc, input string tag, input bit poke_busy);
        result_t r;
        do @(negedge clk); while (!req_ready);
        model(va, acc, r);
        exp_q.push_back(r);
        tag_q.push_back(tag);
        req_vaddr  = va;
        req_access = acc;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            checks++;
            if (req_ready !== 1'b0) begin
                fails++;
                $display("FAIL R1 req_ready during walk: actual %b expected 0", req_ready);
            end
            req_vaddr  = 64'h0000_7777_7777_7000;
            req_access = 2'd0;
            req_valid  = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare each result pulse.
    initial begin
        result_t e;
        result_t a;
        string   t;
        forever begin
            @(negedge clk);
            if (rsp_valid === 1'b1) begin
                a = {rsp_paddr, rsp_fault, rsp_level, rsp_perm_r, rsp_perm_w, rsp_perm_x};
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected response: actual %h expected none", a);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (a !== e) begin
                        fails++;
                        $display("FAIL %s: actual paddr=%h flt=%0d lvl=%0d rwx=%b%b%b expected paddr=%h flt=%0d lvl=%0d rwx=%b%b%b",
                                 t, a.paddr, a.fault, a.level, a.r, a.w, a.x,
                                 e.paddr, e.fault, e.level, e.r, e.w, e.x);
                    end
                end
            end
        end
    end

    // Memory model: variable latency, checks address and single read.
    initial begin
        logic [63:0] d;
        logic [47:0] ea;
        int lat = 0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid === 1'b1) begin
                checks++;
                ea = (addr_q.size() != 0) ? addr_q.pop_front() : 48'hFFFF_FFFF_FFFF;
                if (mem_req_addr !== ea) begin
                    fails++;
                    $display("FAIL R2 descriptor address: actual %h expected %h", mem_req_addr, ea);
                end
                d = rd(mem_req_addr);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                checks++;
                for (int k = 0; k < lat; k++) begin
                    if (mem_req_valid !== 1'b0) begin
                        fails++;
                        $display("FAIL R3 second read outstanding: actual %b expected 0", mem_req_valid);
                    end
                    @(negedge clk);
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = d;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
                lat = (lat + 1) % 4;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog: actual no completion expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] va_ro = 64'h0000_1234_5678_9ABC;
        logic [63:0] va_rw = 64'h0000_1234_5678_A123;
        logic [63:0] va_x  = 64'h0000_0040_0000_0F00;
        logic [63:0] va_t1 = 64'h0000_7F80_4020_1008;
        logic [63:0] va_t3 = 64'h0000_0040_0020_3004;
        repeat (3) @(negedge clk);
        // R9 reset state
        checks++;
        if (req_ready !== 1'b1) begin fails++; $display("FAIL R9 req_ready: actual %b expected 1", req_ready); end
        checks++;
        if (rsp_valid !== 1'b0) begin fails++; $display("FAIL R9 rsp_valid: actual %b expected 0", rsp_valid); end
        checks++;
        if (mem_req_valid !== 1'b0) begin fails++; $display("FAIL R9 mem_req_valid: actual %b expected 0", mem_req_valid); end
        rst_n = 1'b1;

        map_page(va_ro, 48'hABC_DE00_0000, 3'b001);
        map_page(va_rw, 48'h111_2223_3000, 3'b011);
        map_page(va_x,  48'h0F0_0000_5000, 3'b101);
        map_page(va_t1, 48'h000_0000_9000, 3'b111);
        map_page(va_t3, 48'h000_0000_A000, 3'b111);
        // level-1 entry of va_t1 becomes type 10
        tbl[entry_of(va_t1, 1)] = 64'd2;
        // level-3 entry of va_t3 becomes type 01
        tbl[entry_of(va_t3, 3)] = 64'h0000_0000_0000_A01D;

        send(va_ro, 2'd0, "R5 read of read-only page", 1'b0);
        send(va_ro, 2'd1, "R6 write to read-only page", 1'b0);
        send(va_ro, 2'd2, "R6 execute on read-only page", 1'b0);
        send(va_rw, 2'd1, "R5 write to read-write page", 1'b0);
        send(va_rw, 2'd3, "R6 access code 3 as read", 1'b0);
        send(va_x,  2'd2, "R5 execute on exec page", 1'b0);
        send(va_x,  2'd1, "R6 write to exec page", 1'b0);
        send(64'h0000_F000_0000_0000, 2'd0, "R4 empty level 0", 1'b0);
        send(va_ro ^ 64'h0000_0000_0020_0000, 2'd0, "R4 empty level 2", 1'b0);
        send(va_ro ^ 64'h0000_0000_0000_1000, 2'd0, "R4 empty level 3", 1'b0);
        send(va_t1, 2'd0, "R4 type 10 at level 1", 1'b0);
        send(va_t3, 2'd0, "R4 type 01 at level 3", 1'b0);
        send(va_ro | 64'hDEAD_0000_0000_0000, 2'd0, "R7 upper bits ignored", 1'b0);
        send(va_rw, 2'd0, "R1 request during walk ignored", 1'b1);
        root_base = 48'h1FFF;
        send(va_x, 2'd2, "R2 root low bits ignored", 1'b0);
        root_base = 48'h1000;

        repeat (60) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule